// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Program Sequencer

This block sits behind the command decoder of a small serial nonvolatile memory. When a write transaction opens, the decoder hands it the starting array address. Every data byte received after that lands in an eight-slot page buffer. The slot index starts at the low address bits and advances by one per byte, wrapping inside the page. The upper address bits stay fixed.

When chip select rises, the decoder reports whether the rise fell exactly on a byte boundary. The buffer is committed only if all of the following hold:

- at least one whole byte was received;
- the rise was byte-aligned;
- writes are permitted (the write-enable latch is set);
- the write-protect level never went low during the transaction.

A committed page first runs a self-timed programming interval of a programmable number of clock cycles, with busy raised. It then walks the eight slots in ascending order and issues one array write per loaded slot. A slot whose address the neighbouring protect checker flags is skipped. In the last busy cycle the block pulses a request to clear the write-enable latch. While busy, every transaction input and the protect level are ignored.

Top module: `page_prog_seq`

## Requirements
- R1: While reset is low and after its release, busy_o, arr_we_o and wel_clr_o are 0.
- R2: Byte k of a transaction (k = 0, 1, ...) goes to page slot (wr_addr_i[2:0] + k) mod 8 inside page wr_addr_i[8:3]. A later byte for the same slot replaces the earlier one, and every array write of one commit uses the same page bits.
- R3: A commit happens only on cs_rise_i with cs_byte_aligned_i = 1 after at least one byte. A misaligned rise, or a rise with no byte received, writes nothing and leaves busy_o at 0.
- R4: If wr_permit_i = 0 or wp_n_i = 0 in the cs_rise_i cycle, the transaction is discarded: no busy and no write.
- R5: If wp_n_i is 0 in any cycle between wr_start_i and cs_rise_i, the transaction is discarded, even if wp_n_i is back at 1 when chip select rises.
- R6: busy_o rises in the cycle after an accepted cs_rise_i and stays 1 for exactly PROG_CYCLES + 8 cycles.
- R7: Array writes occur only in the last 8 busy cycles, one slot per cycle in ascending slot order. Only loaded slots are written, at address {page, slot} and with the slot's byte.
- R8: A loaded slot is not written in a cycle where chk_prot_i = 1 for the address on arr_addr_o.
- R9: wel_clr_o is a single-cycle pulse in the last busy cycle of every commit.
- R10: While busy_o = 1, wr_start_i, byte_vld_i, cs_rise_i and wp_n_i have no effect. The commit length and written data are unchanged, and no later commit results.
- R11: The buffer starts empty for each transaction, so a commit writes only the slots loaded by that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start_i | input | 1 | Opens a write transaction (address received) |
| wr_addr_i | input | ADDR_W | Starting array address of the transaction |
| byte_vld_i | input | 1 | One full data byte received |
| byte_data_i | input | DATA_W | The received data byte |
| cs_rise_i | input | 1 | Chip select rose this cycle |
| cs_byte_aligned_i | input | 1 | The rise came right after a complete byte |
| wr_permit_i | input | 1 | Write-enable latch is set |
| wp_n_i | input | 1 | Write-protect level, low inhibits writing |
| chk_prot_i | input | 1 | Address on arr_addr_o lies in a protected block |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Programming cycle in progress |
| wel_clr_o | output | 1 | Pulse to clear the write-enable latch |

## Verification
busy_o is due one clock after the edge that takes an accepted cs_rise_i. It then lasts PROG_CYCLES + 8 cycles. Array writes fill the final eight of those cycles, and wel_clr_o marks the very last one. The bench drives inputs and samples outputs on the falling clock edge. It counts busy cycles from the first falling edge after the chip-select-rise edge, and it tallies write strobes and pulses inside that window. Injected stimulus during busy is placed at known busy-cycle offsets, so its absence of effect is seen in the same window and in the array image afterwards.

// File: rtl/pps_pkg.sv
// Shared types for the page program sequencer.
package pps_pkg;
    // Sequencer phases: collecting/idle, timed programming, slot commit walk.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TIMED = 2'd1,
        SEQ_WALK  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/page_buf.sv
// page_buf: eight-slot (2**PAGE_BITS) data buffer with per-slot loaded marks.
// A load opens a page: it latches the page bits and the starting slot and clears
// every mark. Each push writes the current slot, marks it and advances the slot
// modulo the page size. A flush clears the marks.
// Assumes load, push and flush are mutually exclusive per cycle (caller's duty).
module page_buf #(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [ADDR_W-1:0]     load_addr_i,
    input  logic                  push_i,
    input  logic [DATA_W-1:0]     push_data_i,
    input  logic                  flush_i,
    input  logic [PAGE_BITS-1:0]  rd_slot_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic                  rd_valid_o,
    output logic [ADDR_W-PAGE_BITS-1:0] base_o,
    output logic                  filled_o
);
    localparam int SLOTS = 1 << PAGE_BITS;
    localparam int HI_W  = ADDR_W - PAGE_BITS;

    logic [HI_W-1:0]                base_q;
    logic [PAGE_BITS-1:0]           idx_q;
    logic [SLOTS-1:0]               mark_w;
    logic [SLOTS-1:0][DATA_W-1:0]   cell_w;

    // Page bits and fill pointer: set on load, pointer wraps on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            base_q <= load_addr_i[ADDR_W-1:PAGE_BITS];
            idx_q  <= load_addr_i[PAGE_BITS-1:0];
        end else if (push_i) begin
            idx_q  <= idx_q + PAGE_BITS'(1);
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] cell_q;
        logic              mark_q;
        logic              hit;
        assign hit = push_i && (idx_q == PAGE_BITS'(g));

        // Slot storage: captures the byte when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)   cell_q <= '0;
            else if (hit) cell_q <= push_data_i;
        end

        // Loaded mark: cleared on open or flush, set when the slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                   mark_q <= 1'b0;
            else if (load_i || flush_i)   mark_q <= 1'b0;
            else if (hit)                 mark_q <= 1'b1;
        end

        assign cell_w[g] = cell_q;
        assign mark_w[g] = mark_q;
    end

    assign rd_data_o  = cell_w[rd_slot_i];
    assign rd_valid_o = mark_w[rd_slot_i];
    assign base_o     = base_q;
    assign filled_o   = |mark_w;
endmodule

// File: rtl/prog_timer.sv
// prog_timer: one-shot interval timer. start_i arms it; expired_o is high in
// the PROG_CYCLES-th cycle after the arming edge, after which it stops.
// Assumes PROG_CYCLES >= 1; start_i is not raised while it runs.
module prog_timer #(
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int CW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    // Interval counter: runs from 0 to LAST, then stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            else               cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired_o = run_q && (cnt_q == LAST);
endmodule

// File: rtl/page_prog_seq.sv
// page_prog_seq: page write buffer plus self-timed program sequencer.
// Collects data bytes of a write transaction into page_buf. The buffer is
// committed on an aligned chip-select rise when writing is permitted and the
// protect level stayed high. The block then times PROG_CYCLES cycles and walks
// all slots, writing loaded, unprotected ones, and pulses wel_clr_o at the end.
// Assumes the decoder raises wr_start_i, byte_vld_i and cs_rise_i in distinct cycles.
module page_prog_seq
    import pps_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int PAGE_BITS   = 3,
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              cs_rise_i,
    input  logic              cs_byte_aligned_i,
    input  logic              wr_permit_i,
    input  logic              wp_n_i,
    input  logic              chk_prot_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic              busy_o,
    output logic              wel_clr_o
);
    localparam int HI_W = ADDR_W - PAGE_BITS;
    localparam logic [PAGE_BITS-1:0] SLOT_LAST = {PAGE_BITS{1'b1}};

    seq_state_t           state_q;
    logic [PAGE_BITS-1:0] slot_q;
    logic                 collect_q;
    logic                 spoiled_q;

    logic                 idle, open_txn, push, close_txn, commit_ok, flush, walk_end;
    logic                 expired, filled, slot_valid;
    logic [HI_W-1:0]      base;
    logic [DATA_W-1:0]    slot_data;

    assign idle      = (state_q == SEQ_IDLE);
    assign open_txn  = idle && wr_start_i;
    assign push      = idle && collect_q && byte_vld_i;
    assign close_txn = idle && collect_q && cs_rise_i;
    assign commit_ok = close_txn && cs_byte_aligned_i && filled &&
                       wr_permit_i && wp_n_i && !spoiled_q;
    assign walk_end  = (state_q == SEQ_WALK) && (slot_q == SLOT_LAST);
    assign flush     = (close_txn && !commit_ok) || walk_end;

    page_buf #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PAGE_BITS(PAGE_BITS)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (open_txn),
        .load_addr_i(wr_addr_i),
        .push_i     (push),
        .push_data_i(byte_data_i),
        .flush_i    (flush),
        .rd_slot_i  (slot_q),
        .rd_data_o  (slot_data),
        .rd_valid_o (slot_valid),
        .base_o     (base),
        .filled_o   (filled)
    );

    prog_timer #(
        .PROG_CYCLES(PROG_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (commit_ok),
        .expired_o(expired)
    );

    // Transaction tracking: open on start, close on any chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n)          collect_q <= 1'b0;
        else if (open_txn)   collect_q <= 1'b1;
        else if (close_txn)  collect_q <= 1'b0;
    end

    // Protect-level watch: any low level during collection spoils the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)                          spoiled_q <= 1'b0;
        else if (open_txn)                   spoiled_q <= !wp_n_i;
        else if (idle && collect_q && !wp_n_i) spoiled_q <= 1'b1;
    end

    // Phase sequencing: idle -> timed interval -> slot walk -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (commit_ok) state_q <= SEQ_TIMED;
                    slot_q <= '0;
                end
                SEQ_TIMED: begin
                    if (expired) state_q <= SEQ_WALK;
                    slot_q <= '0;
                end
                SEQ_WALK: begin
                    slot_q <= slot_q + PAGE_BITS'(1);
                    if (slot_q == SLOT_LAST) state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign arr_addr_o  = {base, slot_q};
    assign arr_wdata_o = slot_data;
    assign arr_we_o    = (state_q == SEQ_WALK) && slot_valid && !chk_prot_i;
    assign busy_o      = !idle;
    assign wel_clr_o   = walk_end;
endmodule

// File: rtl/page_prog_seq_chk.sv
// page_prog_seq_chk: protocol checker for page_prog_seq, bound to every instance.
// Observes ports only; assumes synchronous active-low reset.
module page_prog_seq_chk #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_BITS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise_i,
    input logic              cs_byte_aligned_i,
    input logic              wr_permit_i,
    input logic              wp_n_i,
    input logic              chk_prot_i,
    input logic              arr_we_o,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic              busy_o,
    input logic              wel_clr_o
);
    // R1: outputs quiet after a reset cycle
    p_rst_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !arr_we_o && !wel_clr_o));

    // R2: one commit stays inside one page
    p_same_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o && $past(arr_we_o) |->
        arr_addr_o[ADDR_W-1:PAGE_BITS] == $past(arr_addr_o[ADDR_W-1:PAGE_BITS]));

    // R3: busy starts only from an aligned, permitted chip-select rise
    p_commit_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cs_rise_i && cs_byte_aligned_i && wr_permit_i && wp_n_i));

    // R3: misaligned rise never starts a cycle
    p_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && cs_rise_i && !cs_byte_aligned_i |=> !busy_o);

    // R4: denied rise never starts a cycle
    p_denied_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && cs_rise_i && !(wr_permit_i && wp_n_i) |=> !busy_o);

    // R7: writes only while busy
    p_we_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);

    // R7: back-to-back writes go to ascending slots
    p_slot_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o && $past(arr_we_o) |->
        arr_addr_o[PAGE_BITS-1:0] == PAGE_BITS'($past(arr_addr_o[PAGE_BITS-1:0]) + 1'b1));

    // R8: protected address never written
    p_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> !chk_prot_i);

    // R9: latch-clear pulse is inside busy, one cycle, and ends busy
    p_wel_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |-> busy_o);
    p_wel_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |=> (!wel_clr_o && !busy_o));

    // R10: busy cannot be cut short by any input
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !wel_clr_o |=> busy_o);
endmodule

bind page_prog_seq page_prog_seq_chk #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
) u_chk (.*);

// File: tb/page_prog_seq_tb.sv
module page_prog_seq_tb;
    localparam int PROG  = 16;
    localparam int SLOTS = 8;

    typedef struct packed {
        logic [8:0] addr;
        logic [4:0] n;
        logic [7:0] seed;
        logic       al;
        logic       ok;
        logic [1:0] wpm;   // 0 high, 1 low at rise, 2 low pulse during bytes
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{9'h013, 5'd3,  8'hA0, 1'b1, 1'b1, 2'd0},
        '{9'h1FE, 5'd4,  8'h10, 1'b1, 1'b1, 2'd0},
        '{9'h020, 5'd10, 8'h40, 1'b1, 1'b1, 2'd0},
        '{9'h030, 5'd2,  8'h55, 1'b0, 1'b1, 2'd0},
        '{9'h038, 5'd0,  8'h66, 1'b1, 1'b1, 2'd0},
        '{9'h040, 5'd2,  8'h70, 1'b1, 1'b0, 2'd0},
        '{9'h048, 5'd2,  8'h80, 1'b1, 1'b1, 2'd1},
        '{9'h058, 5'd2,  8'h90, 1'b1, 1'b1, 2'd2},
        '{9'h025, 5'd1,  8'h77, 1'b1, 1'b1, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0;
    logic [8:0] wr_addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cs_rise = 1'b0;
    logic       cs_al = 1'b0;
    logic       permit = 1'b1;
    logic       wp_n = 1'b1;
    logic       prot_on = 1'b0;
    logic [8:0] prot_lo = '0;
    logic       chk_prot;
    logic       arr_we;
    logic [8:0] arr_addr;
    logic [7:0] arr_wdata;
    logic       busy;
    logic       wel_clr;

    int n_chk = 0;
    int n_fail = 0;
    int we_seen = 0;
    logic [7:0] bmem [512];
    logic [7:0] emem [512];

    always #5 clk = ~clk;

    assign chk_prot = prot_on && (arr_addr >= prot_lo);

    page_prog_seq #(
        .ADDR_W(9), .DATA_W(8), .PAGE_BITS(3), .PROG_CYCLES(PROG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_start_i(wr_start), .wr_addr_i(wr_addr),
        .byte_vld_i(byte_vld), .byte_data_i(byte_data), .cs_rise_i(cs_rise),
        .cs_byte_aligned_i(cs_al), .wr_permit_i(permit), .wp_n_i(wp_n),
        .chk_prot_i(chk_prot), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
        .arr_wdata_o(arr_wdata), .busy_o(busy), .wel_clr_o(wel_clr)
    );

    // Array model driven by the write strobe
    always @(negedge clk) begin
        if (arr_we) begin
            bmem[arr_addr] = arr_wdata;
            we_seen++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < 512; a++) begin
            if (bmem[a] !== emem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (first >= 0)
            $display("  mismatch at %0h actual=%0h expected=%0h", first, bmem[first], emem[first]);
        check(tag, bad, 0);
    endtask

    // Expected effect of one transaction, from the requirements
    task automatic model(input logic [8:0] a, input int n, input logic [7:0] seed,
                         input logic acc, output int exp_we);
        logic [7:0] val [SLOTS];
        logic       set [SLOTS];
        exp_we = 0;
        for (int s = 0; s < SLOTS; s++) set[s] = 1'b0;
        for (int i = 0; i < n; i++) begin
            int s = int'(3'(a[2:0] + 3'(i)));
            val[s] = seed + 8'(i);
            set[s] = 1'b1;
        end
        if (acc) begin
            for (int s = 0; s < SLOTS; s++) begin
                logic [8:0] ad = {a[8:3], 3'(s)};
                if (set[s] && !(prot_on && ad >= prot_lo)) begin
                    emem[ad] = val[s];
                    exp_we++;
                end
            end
        end
    endtask

    task automatic run_txn(input logic [8:0] a, input int n, input logic [7:0] seed,
                           input logic al, input logic ok, input logic [1:0] wpm,
                           input logic inject, output int blen, output int wcnt);
        we_seen = 0;
        @(negedge clk); wr_start = 1'b1; wr_addr = a;
        @(negedge clk); wr_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_data = seed + 8'(i);
            if (wpm == 2'd2 && i == 0) wp_n = 1'b0;
            @(negedge clk); byte_vld = 1'b0; wp_n = 1'b1;
        end
        cs_rise = 1'b1; cs_al = al; permit = ok;
        if (wpm == 2'd1) wp_n = 1'b0;
        @(negedge clk); cs_rise = 1'b0; cs_al = 1'b0; permit = 1'b1; wp_n = 1'b1;
        blen = 0; wcnt = 0;
        while (busy && blen < 1000) begin
            blen++;
            if (wel_clr) wcnt++;
            if (inject) begin
                case (blen)
                    2: begin wr_start = 1'b1; wr_addr = 9'h060; end
                    3: begin wr_start = 1'b0; byte_vld = 1'b1; byte_data = 8'h99; end
                    4: begin byte_vld = 1'b0; cs_rise = 1'b1; cs_al = 1'b1; end
                    5: begin cs_rise = 1'b0; cs_al = 1'b0; wp_n = 1'b0; end
                    6: wp_n = 1'b1;
                    default: ;
                endcase
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int blen, wcnt, ewe;
        logic acc;
        for (int a = 0; a < 512; a++) begin bmem[a] = 8'h00; emem[a] = 8'h00; end

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", int'({busy, arr_we, wel_clr}), 0);

        // Table walk: R2 wrap/overwrite, R3 alignment/empty, R4 permit/level,
        // R5 mid-transaction protect pulse, R11 fresh buffer per transaction
        for (int v = 0; v < 9; v++) begin
            vec_t t = VECS[v];
            string id = $sformatf("vec%0d", v);
            acc = t.al && (t.n != 0) && t.ok && (t.wpm == 2'd0);
            run_txn(t.addr, int'(t.n), t.seed, t.al, t.ok, t.wpm, 1'b0, blen, wcnt);
            model(t.addr, int'(t.n), t.seed, acc, ewe);
            check({"R6 busy length ", id}, blen, acc ? PROG + SLOTS : 0);
            check({"R9 latch-clear pulses ", id}, wcnt, acc ? 1 : 0);
            check({"R7 R11 R3 R4 R5 write count ", id}, we_seen, ewe);
            check_mem({"R2 R7 array image ", id});
        end

        // R8: upper half of a page protected
        prot_on = 1'b1; prot_lo = 9'h104;
        run_txn(9'h100, 8, 8'hC0, 1'b1, 1'b1, 2'd0, 1'b0, blen, wcnt);
        model(9'h100, 8, 8'hC0, 1'b1, ewe);
        check("R8 busy length", blen, PROG + SLOTS);
        check("R8 write count", we_seen, 4);
        check("R8 model write count", ewe, 4);
        check_mem("R8 array image");
        prot_on = 1'b0;

        // R10: inputs toggled during busy are ignored
        run_txn(9'h050, 1, 8'h3C, 1'b1, 1'b1, 2'd0, 1'b1, blen, wcnt);
        model(9'h050, 1, 8'h3C, 1'b1, ewe);
        check("R10 busy length with injected traffic", blen, PROG + SLOTS);
        check("R10 latch-clear pulses", wcnt, 1);
        check("R10 write count", we_seen, ewe);
        check_mem("R10 array image");
        blen = 0;
        for (int i = 0; i < 5; i++) begin
            if (busy) blen++;
            @(negedge clk);
        end
        check("R10 no commit after busy", blen, 0);

        finish_run();
    end
endmodule